// File: doc/BRIEF.md
# Self-Advancing ROM Bank Counter

This block drives the upper address lines of an external ROM that the CPU sees through a single 4 KB window at $5000-$5FFF. The CPU never writes the bank number. A bank counter steps forward by one each time a bus cycle that targets the window ends, which happens on the falling edge of the bus clock M2. Reading the same window address again and again therefore walks through the ROM one 4 KB page at a time, and the window acts as a sequential streaming port.

The ROM address is formed by placing the bank value at bit 12 and above and combining it with the CPU's low twelve address lines. The counter is five bits wide and wraps after 32 banks. A sixth bank line, the top ROM address bit, comes from a separate select input so that the upper half of the ROM can be reached. The block also decodes the window and drives the ROM chip enable, which is active low.

M2 is sampled by the block clock, and its falling edge is detected as the cycle in which a sampled high is followed by a low.

Top module: `rom_bank_counter`

## Requirements
- R1: `romCeN` is 0 exactly when `cpuAddr[15:12]` equals 4'h5, which is the $5000-$5FFF window. It is 1 for every other address.
- R2: When a clock edge sees `m2` low, `m2` was high at the previous edge, and `cpuAddr` is inside the window, the bank count (`romHiAddr[4:0]`) rises by one at that edge.
- R3: A falling edge of M2 while `cpuAddr` is outside the window leaves the bank count unchanged.
- R4: The bank count wraps from 31 to 0, giving 32 banks.
- R5: While `rstN` is 0, the bank count is 0.
- R6: `romAddr[11:0]` equals `cpuAddr[11:0]`, and `romAddr[17:12]` equals `romHiAddr`, so the address seen during an access uses the bank value held before that access advances it.
- R7: `romHiAddr[5]` follows `upperSel`, and `upperSel` never changes the bank count.
- R8: M2 held high for several clocks, or held low, does not advance the count. Only the high-to-low transition does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples M2 |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuAddr | input | 16 | CPU address bus |
| m2 | input | 1 | Bus clock; each access ends on its falling edge |
| upperSel | input | 1 | Selects the upper half of the ROM (top address bit) |
| romCeN | output | 1 | ROM chip enable, active low, for the window |
| romHiAddr | output | 6 | ROM address bits 12 to 17 |
| romAddr | output | 18 | Full ROM address |

## Verification
On every cycle, the assertions check four things: the window decode against the address, the one-step advance with 5-bit wrap on a falling edge inside the window, the hold of the count on all other edges, and the way the ROM address is built from the bank lines and the low CPU address lines. Only the bench scenarios can show the long-range behaviour. One is a streamed run of more than 32 reads of a single address, which shows the pages arriving in order and wrapping back to page 0. Others show a held-high M2 giving exactly one step, out-of-window cycles mixed into the stream without disturbing it, and a reset in mid-stream returning to page 0.

// File: rtl/rom_bank_pkg.sv
package rom_bank_pkg;

  // Strobes sent from control to datapath
  typedef struct packed {
    logic advance;   // step the bank count at this clock edge
  } bankStrobe_t;

endpackage

// File: rtl/rom_bank_ctrl.sv
module rom_bank_ctrl
  import rom_bank_pkg::*;
#(
  parameter int DEC_W = 4,
  parameter logic [DEC_W-1:0] WIN_BASE = 4'h5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DEC_W-1:0] addrHi,
  input  logic             m2,
  output bankStrobe_t      strobe,
  output logic             romCeN
);

  logic m2Prev;
  logic inWindow;
  logic m2Fall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) m2Prev <= 1'b0;
    else       m2Prev <= m2;
  end

  always_comb begin
    inWindow       = (addrHi == WIN_BASE);
    m2Fall         = m2Prev & ~m2;
    strobe.advance = m2Fall & inWindow;
    romCeN         = ~inWindow;
  end

endmodule

// File: rtl/rom_bank_datapath.sv
module rom_bank_datapath
  import rom_bank_pkg::*;
#(
  parameter int WIN_BITS = 12,
  parameter int CNT_W    = 5,
  localparam int HI_W    = CNT_W + 1,
  localparam int ROM_W   = WIN_BITS + HI_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  bankStrobe_t         strobe,
  input  logic                upperSel,
  input  logic [WIN_BITS-1:0] cpuLow,
  output logic [HI_W-1:0]     romHiAddr,
  output logic [ROM_W-1:0]    romAddr
);

  logic [CNT_W-1:0] bankCnt;

  // Free-running wrap: the count rolls over naturally at 2**CNT_W
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               bankCnt <= '0;
    else if (strobe.advance) bankCnt <= bankCnt + 1'b1;
  end

  assign romHiAddr = {upperSel, bankCnt};

  // Low bits pass straight through, high bits take the bank lines
  for (genvar i = 0; i < ROM_W; i++) begin : g_addr
    if (i < WIN_BITS) begin : g_low
      assign romAddr[i] = cpuLow[i];
    end else begin : g_high
      assign romAddr[i] = romHiAddr[i-WIN_BITS];
    end
  end

endmodule

// File: rtl/rom_bank_counter.sv
module rom_bank_counter
  import rom_bank_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int WIN_BITS = 12,
  parameter int CNT_W    = 5,
  parameter logic [ADDR_W-WIN_BITS-1:0] WIN_BASE = 4'h5,
  localparam int DEC_W   = ADDR_W - WIN_BITS,
  localparam int HI_W    = CNT_W + 1,
  localparam int ROM_W   = WIN_BITS + HI_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              m2,
  input  logic              upperSel,
  output logic              romCeN,
  output logic [HI_W-1:0]   romHiAddr,
  output logic [ROM_W-1:0]  romAddr
);

  bankStrobe_t strobe;

  rom_bank_ctrl #(
    .DEC_W   (DEC_W),
    .WIN_BASE(WIN_BASE)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .addrHi(cpuAddr[ADDR_W-1:WIN_BITS]),
    .m2    (m2),
    .strobe(strobe),
    .romCeN(romCeN)
  );

  rom_bank_datapath #(
    .WIN_BITS(WIN_BITS),
    .CNT_W   (CNT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .upperSel (upperSel),
    .cpuLow   (cpuAddr[WIN_BITS-1:0]),
    .romHiAddr(romHiAddr),
    .romAddr  (romAddr)
  );

endmodule

// File: rtl/rom_bank_counter_chk.sv
module rom_bank_counter_chk #(
  parameter int ADDR_W   = 16,
  parameter int WIN_BITS = 12,
  parameter int CNT_W    = 5,
  parameter logic [ADDR_W-WIN_BITS-1:0] WIN_BASE = 4'h5,
  localparam int HI_W    = CNT_W + 1,
  localparam int ROM_W   = WIN_BITS + HI_W
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic              m2,
  input logic              upperSel,
  input logic              romCeN,
  input logic [HI_W-1:0]   romHiAddr,
  input logic [ROM_W-1:0]  romAddr
);

  logic m2Seen;
  logic hit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) m2Seen <= 1'b0;
    else       m2Seen <= m2;
  end

  assign hit = (cpuAddr[ADDR_W-1:WIN_BITS] == WIN_BASE);

  AST_CE_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    romCeN == !hit); // R1

  AST_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (m2Seen && !m2 && hit) |=>
      romHiAddr[CNT_W-1:0] == CNT_W'($past(romHiAddr[CNT_W-1:0]) + 1'b1)); // R2

  AST_HOLD_OUTSIDE: assert property (@(posedge clk) disable iff (!rstN)
    (m2Seen && !m2 && !hit) |=> $stable(romHiAddr[CNT_W-1:0])); // R3

  AST_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (m2Seen && !m2 && hit && romHiAddr[CNT_W-1:0] == '1) |=>
      romHiAddr[CNT_W-1:0] == '0); // R4

  always @(posedge clk) begin
    if (!rstN) begin
      AST_RESET_CLEAR: assert (romHiAddr[CNT_W-1:0] == '0); // R5
    end
  end

  AST_ADDR_FORM: assert property (@(posedge clk) disable iff (!rstN)
    romAddr == {romHiAddr, cpuAddr[WIN_BITS-1:0]}); // R6

  AST_TOP_BIT: assert property (@(posedge clk) disable iff (!rstN)
    romHiAddr[HI_W-1] == upperSel); // R7

  AST_NO_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(m2Seen && !m2) |=> $stable(romHiAddr[CNT_W-1:0])); // R8

endmodule

bind rom_bank_counter rom_bank_counter_chk #(
  .ADDR_W  (ADDR_W),
  .WIN_BITS(WIN_BITS),
  .CNT_W   (CNT_W),
  .WIN_BASE(WIN_BASE)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cpuAddr  (cpuAddr),
  .m2       (m2),
  .upperSel (upperSel),
  .romCeN   (romCeN),
  .romHiAddr(romHiAddr),
  .romAddr  (romAddr)
);

// File: tb/tb_rom_bank_counter.sv
module tb_rom_bank_counter;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [17:0] addr;
    logic        ceN;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = 16'h0000;
  logic        m2 = 1'b0;
  logic        upperSel = 1'b0;
  logic        romCeN;
  logic [5:0]  romHiAddr;
  logic [17:0] romAddr;

  int    checks = 0;
  int    errors = 0;
  int    bank = 0;
  bit    done = 0;
  item_t sb[$];
  event  sampleEv;

  always #(CLK_PERIOD/2) clk = ~clk;

  rom_bank_counter dut (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .m2(m2),
    .upperSel(upperSel), .romCeN(romCeN),
    .romHiAddr(romHiAddr), .romAddr(romAddr)
  );

  function automatic logic inWin(input logic [15:0] a);
    return a[15:12] == 4'h5;
  endfunction

  task automatic pushExpect(input logic [15:0] a, input logic up, input string tag);
    item_t it;
    it.addr = {up, 5'(bank), a[11:0]};
    it.ceN  = !inWin(a);
    it.tag  = tag;
    sb.push_back(it);
    -> sampleEv;
  endtask

  // Driver: one bus cycle, M2 high for highCycles clocks, then falls
  task automatic access(input logic [15:0] a, input logic up,
                        input int highCycles, input string tag);
    @(negedge clk);
    cpuAddr  = a;
    upperSel = up;
    m2       = 1'b1;
    pushExpect(a, up, tag);
    for (int i = 0; i < highCycles; i++) begin
      @(posedge clk);
      if (i > 0) begin
        @(negedge clk);
        pushExpect(a, up, "R8 held-high");
      end
    end
    @(negedge clk);
    m2 = 1'b0;
    @(posedge clk);
    if (inWin(a)) bank = (bank + 1) % 32;
  endtask

  // Monitor: pop and compare once outputs settle
  initial begin
    forever begin
      item_t it;
      @(sampleEv);
      #1;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL scoreboard empty romAddr=%h", romAddr);
      end else begin
        it = sb.pop_front();
        checks += 2;
        if (romAddr !== it.addr) begin
          errors++;
          $display("FAIL %s romAddr=%h expected=%h", it.tag, romAddr, it.addr);
        end
        if (romCeN !== it.ceN) begin
          errors++;
          $display("FAIL R1 (%s) romCeN=%b expected=%b", it.tag, romCeN, it.ceN);
        end
      end
    end
  end

  task automatic checkReset();
    #1;
    checks++;
    if (romHiAddr[4:0] !== 5'd0) begin
      errors++;
      $display("FAIL R5 romHiAddr=%h expected=00", romHiAddr);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    checkReset();                         // R5 during reset
    @(negedge clk);
    rstN = 1'b1;

    // R2 / R4: stream through more than 32 banks from one address
    for (int k = 0; k < 36; k++)
      access(16'h5000, 1'b0, 1, (bank == 31) ? "R4 wrap" : "R2 stream");

    // R6: varied low address bits
    access(16'h5ABC, 1'b0, 1, "R6 low bits");
    access(16'h5FFF, 1'b0, 1, "R6 top of window");

    // R3 / R1: out-of-window cycles do not step the count
    access(16'h4FFF, 1'b0, 1, "R3 below window");
    access(16'h6000, 1'b0, 1, "R3 above window");
    access(16'hD123, 1'b0, 1, "R3 high page");
    access(16'h5001, 1'b0, 1, "R3 count unchanged");

    // R7: top bit from upperSel, count unaffected
    access(16'h5222, 1'b1, 1, "R7 upper half");
    access(16'h5333, 1'b1, 1, "R7 upper half");
    access(16'h5444, 1'b0, 1, "R7 lower again");

    // R8: M2 held high several clocks gives one step only
    access(16'h5010, 1'b0, 4, "R8 held-high");
    access(16'h5020, 1'b0, 1, "R8 single step");
    repeat (5) @(posedge clk);           // M2 held low
    access(16'h5030, 1'b0, 1, "R8 held-low");

    // R5: reset in mid-stream
    @(negedge clk);
    rstN = 1'b0;
    @(posedge clk);
    checkReset();
    bank = 0;
    @(negedge clk);
    rstN = 1'b1;
    access(16'h5000, 1'b0, 1, "R5 after reset");
    access(16'h5000, 1'b0, 1, "R2 after reset");

    @(negedge clk);
    #2;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule